// File: doc/BRIEF.md
# Fixed-Latency Burst Timing Generator

This block schedules when a two-port memory device's data buses are busy. It does not hold any data. Each port accepts a read or write command. A fixed number of clock cycles later, the block raises the strobes that move that command's two-word burst. For a read, it raises a data-valid window on that port. For a write, it raises a capture enable. A speed-grade input chooses between two latency pairs. In the slow grade, reads return after 5 cycles and writes are captured after 3. In the fast, banked grade, reads return after 8 cycles and writes are captured after 5.

The logic runs on a tick equal to half of the device clock. The block tracks which half it is in and reports it on `phaseFall`. Port A commands are taken only in the rising half, and port B commands only in the falling half. Every half-cycle relation therefore becomes a whole-tick offset.

For each port the block also produces two further signals. One is a valid strobe that leads the read data by one tick and drops one tick before the last word. The other is a drive enable that covers the strobe and the data and releases the bus straight after the last word. The speed grade must not change while commands are in flight. When it does change, the block discards every scheduled event.

Top module: `latency_timing_gen`

## Requirements
- R1: While `rst` is high and in the first tick after it falls, all eight strobe outputs are low and `phaseFall` is 0.
- R2: `phaseFall` toggles on every clock edge after reset, starting at 0 (rising half).
- R3: Port A commands are taken only in a tick with `phaseFall`=0, and port B commands only in a tick with `phaseFall`=1. A command presented in the other half is ignored and produces no strobe.
- R4: With `speedHigh`=0, a read taken at edge E drives `rdValid` high in the ticks following edges E+10 and E+11 (two words, 5 cycles).
- R5: With `speedHigh`=1, a read taken at edge E drives `rdValid` high after edges E+16 and E+17 (8 cycles).
- R6: A write taken at edge E drives `wrCapture` high for two ticks: after E+6 and E+7 when `speedHigh`=0, and after E+10 and E+11 when `speedHigh`=1.
- R7: `validStrobe` is high in the tick before the first read word and during the first word, and low during the last word.
- R8: `driveEn` is high from the tick before the first read word through the last word, and low in the tick after the last word unless another burst follows.
- R9: Reads taken on a port in consecutive cycles keep `validStrobe` and `driveEn` high with no gap between bursts.
- R10: When `speedHigh` differs from the grade in use at a clock edge, every scheduled strobe of both ports is cancelled and a command offered at that edge is dropped. Commands taken afterwards follow the new grade.
- R11: The two ports are scheduled independently, so interleaved reads and writes on A and B each produce their own strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock |
| rst | input | 1 | Synchronous reset, active high |
| speedHigh | input | 1 | Speed grade: 0 = 5/3-cycle latencies, 1 = 8/5-cycle latencies |
| cmdValidA | input | 1 | Port A command present |
| cmdWriteA | input | 1 | Port A command is a write (1) or a read (0) |
| cmdValidB | input | 1 | Port B command present |
| cmdWriteB | input | 1 | Port B command is a write (1) or a read (0) |
| phaseFall | output | 1 | Current tick is the falling half of the device clock |
| rdValidA | output | 1 | Port A read word on the bus |
| wrCaptureA | output | 1 | Port A write word to be captured |
| validStrobeA | output | 1 | Port A read-valid strobe, one tick ahead of the data |
| driveEnA | output | 1 | Port A output driver enable |
| rdValidB | output | 1 | Port B read word on the bus |
| wrCaptureB | output | 1 | Port B write word to be captured |
| validStrobeB | output | 1 | Port B read-valid strobe, one tick ahead of the data |
| driveEnB | output | 1 | Port B output driver enable |

## Verification
The hardest case to reach from the ports is a grade change that lands while bursts are still in the pipeline. To reach it, the stimulus issues a port A read and a port B write, waits only a few ticks, and then flips `speedHigh` in the same tick as a fresh read. It checks that none of the in-flight or newly offered commands ever produce a strobe. A further hazard is a command offered in the wrong half-cycle. To cover it, the stimulus deliberately presents port A in a falling tick and port B in a rising tick. Cycle-accurate windows for both grades come from a per-tick expectation table that the driver fills as each command is issued.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int NUM_PORTS = 2;

  typedef struct packed {
    logic rd;
    logic wr;
  } laneCmd_t;

  typedef struct packed {
    logic                         flush;
    logic                         modeHigh;
    laneCmd_t [NUM_PORTS-1:0]     acc;
  } ctrlStrobe_t;

  typedef struct packed {
    logic rdValid;
    logic wrCapture;
    logic validStrobe;
    logic driveEn;
  } laneOut_t;

endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 speedHigh,
  input  logic [NUM_PORTS-1:0] cmdValid,
  input  logic [NUM_PORTS-1:0] cmdWrite,
  output ctrlStrobe_t          strobe,
  output logic                 phaseFall
);

  logic phaseQ;
  logic modeQ;
  logic modeChange;

  assign modeChange = (speedHigh != modeQ);

  // Half-cycle phase and latched speed grade
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= 1'b0;
      modeQ  <= speedHigh;
    end else begin
      phaseQ <= ~phaseQ;
      if (modeChange) modeQ <= speedHigh;
    end
  end

  // Port p owns the half whose phase equals p[0]
  always_comb begin
    strobe.flush    = modeChange;
    strobe.modeHigh = modeQ;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic slotOk;
      slotOk = (phaseQ == p[0]) && cmdValid[p] && !modeChange;
      strobe.acc[p].rd = slotOk && !cmdWrite[p];
      strobe.acc[p].wr = slotOk &&  cmdWrite[p];
    end
  end

  assign phaseFall = phaseQ;

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phaseQ != $past(phaseQ)));

  assert_portA_rising_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.acc[0] != '0) |=> phaseQ);

  assert_portB_falling_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.acc[1] != '0) |=> !phaseQ);

  assert_mode_adopt_R10: assert property (@(posedge clk) disable iff (rst)
    modeChange |=> (modeQ == $past(speedHigh)));

endmodule

// File: rtl/dtg_lane.sv
module dtg_lane
  import dtg_pkg::*;
#(
  parameter int RD_LO = 5,
  parameter int WR_LO = 3,
  parameter int RD_HI = 8,
  parameter int WR_HI = 5
)(
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     modeHigh,
  input  logic     accRd,
  input  logic     accWr,
  output laneOut_t laneOut
);

  localparam int RD_MAX   = (RD_HI > RD_LO) ? RD_HI : RD_LO;
  localparam int WR_MAX   = (WR_HI > WR_LO) ? WR_HI : WR_LO;
  localparam int RD_DEPTH = 2 * RD_MAX + 2;
  localparam int WR_DEPTH = 2 * WR_MAX + 2;
  localparam int RD_TAP_LO = 2 * RD_LO;
  localparam int RD_TAP_HI = 2 * RD_HI;
  localparam int WR_TAP_LO = 2 * WR_LO;
  localparam int WR_TAP_HI = 2 * WR_HI;

  logic [RD_DEPTH-1:0] rdPipe;
  logic [WR_DEPTH-1:0] wrPipe;

  // One stage per tick; stage j holds a command taken j edges ago
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rdPipe <= '0;
      wrPipe <= '0;
    end else begin
      rdPipe <= {rdPipe[RD_DEPTH-2:0], accRd};
      wrPipe <= {wrPipe[WR_DEPTH-2:0], accWr};
    end
  end

  logic preWord, firstWord, lastWord;

  always_comb begin
    if (modeHigh) begin
      preWord   = rdPipe[RD_TAP_HI-1];
      firstWord = rdPipe[RD_TAP_HI];
      lastWord  = rdPipe[RD_TAP_HI+1];
      laneOut.wrCapture = wrPipe[WR_TAP_HI] | wrPipe[WR_TAP_HI+1];
    end else begin
      preWord   = rdPipe[RD_TAP_LO-1];
      firstWord = rdPipe[RD_TAP_LO];
      lastWord  = rdPipe[RD_TAP_LO+1];
      laneOut.wrCapture = wrPipe[WR_TAP_LO] | wrPipe[WR_TAP_LO+1];
    end
    laneOut.rdValid     = firstWord | lastWord;
    laneOut.validStrobe = preWord | firstWord;
    laneOut.driveEn     = preWord | firstWord | lastWord;
  end

  assert_strobe_leads_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(laneOut.rdValid) |-> $past(laneOut.validStrobe));

  assert_release_after_word_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(laneOut.driveEn) && !$past(flush)) |-> $past(laneOut.rdValid));

  assert_write_pair_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(laneOut.wrCapture) && !flush) |=> laneOut.wrCapture);

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!laneOut.driveEn && !laneOut.wrCapture));

endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int RD_LO = 5,
  parameter int WR_LO = 3,
  parameter int RD_HI = 8,
  parameter int WR_HI = 5
)(
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobe_t              strobe,
  output laneOut_t [NUM_PORTS-1:0] lanes
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gLane
    dtg_lane #(
      .RD_LO(RD_LO), .WR_LO(WR_LO), .RD_HI(RD_HI), .WR_HI(WR_HI)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .flush    (strobe.flush),
      .modeHigh (strobe.modeHigh),
      .accRd    (strobe.acc[g].rd),
      .accWr    (strobe.acc[g].wr),
      .laneOut  (lanes[g])
    );
  end

endmodule

// File: rtl/latency_timing_gen.sv
module latency_timing_gen
  import dtg_pkg::*;
#(
  parameter int RD_LO = 5,
  parameter int WR_LO = 3,
  parameter int RD_HI = 8,
  parameter int WR_HI = 5
)(
  input  logic clk,
  input  logic rst,
  input  logic speedHigh,
  input  logic cmdValidA,
  input  logic cmdWriteA,
  input  logic cmdValidB,
  input  logic cmdWriteB,
  output logic phaseFall,
  output logic rdValidA,
  output logic wrCaptureA,
  output logic validStrobeA,
  output logic driveEnA,
  output logic rdValidB,
  output logic wrCaptureB,
  output logic validStrobeB,
  output logic driveEnB
);

  ctrlStrobe_t              strobe;
  laneOut_t [NUM_PORTS-1:0] lanes;

  dtg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .speedHigh (speedHigh),
    .cmdValid  ({cmdValidB, cmdValidA}),
    .cmdWrite  ({cmdWriteB, cmdWriteA}),
    .strobe    (strobe),
    .phaseFall (phaseFall)
  );

  dtg_datapath #(
    .RD_LO(RD_LO), .WR_LO(WR_LO), .RD_HI(RD_HI), .WR_HI(WR_HI)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .lanes  (lanes)
  );

  assign rdValidA     = lanes[0].rdValid;
  assign wrCaptureA   = lanes[0].wrCapture;
  assign validStrobeA = lanes[0].validStrobe;
  assign driveEnA     = lanes[0].driveEn;
  assign rdValidB     = lanes[1].rdValid;
  assign wrCaptureB   = lanes[1].wrCapture;
  assign validStrobeB = lanes[1].validStrobe;
  assign driveEnB     = lanes[1].driveEn;

endmodule

// File: tb/test_latency_timing_gen.sv
`timescale 1ns/1ps
module test_latency_timing_gen;

  localparam int RD_LO = 5, WR_LO = 3, RD_HI = 8, WR_HI = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speedHigh = 1'b0;
  logic cmdValidA = 1'b0, cmdWriteA = 1'b0, cmdValidB = 1'b0, cmdWriteB = 1'b0;
  logic phaseFall;
  logic rdValidA, wrCaptureA, validStrobeA, driveEnA;
  logic rdValidB, wrCaptureB, validStrobeB, driveEnB;

  always #2 clk = ~clk;

  latency_timing_gen i_latency_timing_gen (
    .clk(clk), .rst(rst), .speedHigh(speedHigh),
    .cmdValidA(cmdValidA), .cmdWriteA(cmdWriteA),
    .cmdValidB(cmdValidB), .cmdWriteB(cmdWriteB),
    .phaseFall(phaseFall),
    .rdValidA(rdValidA), .wrCaptureA(wrCaptureA),
    .validStrobeA(validStrobeA), .driveEnA(driveEnA),
    .rdValidB(rdValidB), .wrCaptureB(wrCaptureB),
    .validStrobeB(validStrobeB), .driveEnB(driveEnB)
  );

  int compared = 0;
  int mismatched = 0;
  int tickN = 0;
  bit curMode = 1'b0;
  bit monOn = 1'b0;
  string curReq = "R1";
  logic [7:0] expTab [int];

  // bit layout per port (A at 0, B at 4): rd, wr, strobe, drive
  function automatic logic [7:0] outVec();
    return {driveEnB, validStrobeB, wrCaptureB, rdValidB,
            driveEnA, validStrobeA, wrCaptureA, rdValidA};
  endfunction

  always @(posedge clk) begin
    if (rst) tickN <= 0;
    else     tickN <= tickN + 1;
  end

  task automatic markTick(input int t, input logic [7:0] m);
    if (expTab.exists(t)) expTab[t] = expTab[t] | m;
    else                  expTab[t] = m;
  endtask

  task automatic pushCmd(input int port, input bit isWr);
    int e, rl, wl, sh;
    e  = tickN + 1;
    rl = 2 * (curMode ? RD_HI : RD_LO);
    wl = 2 * (curMode ? WR_HI : WR_LO);
    sh = port * 4;
    if (isWr) begin
      markTick(e + wl,     8'b0010 << sh);
      markTick(e + wl + 1, 8'b0010 << sh);
    end else begin
      markTick(e + rl - 1, 8'b1100 << sh);
      markTick(e + rl,     8'b1101 << sh);
      markTick(e + rl + 1, 8'b1001 << sh);
    end
  endtask

  // Drive one tick of stimulus at a falling clk edge and record expectations
  task automatic step(input bit aV, input bit aW, input bit bV, input bit bW, input bit md);
    cmdValidA = aV; cmdWriteA = aW; cmdValidB = bV; cmdWriteB = bW; speedHigh = md;
    if (md != curMode) begin
      int doomed[$];
      foreach (expTab[k]) if (k > tickN) doomed.push_back(k);
      foreach (doomed[i]) expTab.delete(doomed[i]);
      curMode = md;
    end else begin
      if (aV && (tickN % 2 == 0)) pushCmd(0, aW);
      if (bV && (tickN % 2 == 1)) pushCmd(1, bW);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, curMode);
  endtask

  task automatic alignA();
    if (tickN % 2 == 1) idle(1);
  endtask

  // Monitor: compare every tick against the expectation table
  always @(negedge clk) begin
    if (monOn) begin
      logic [7:0] want;
      logic [7:0] got;
      want = expTab.exists(tickN) ? expTab[tickN] : 8'h00;
      got  = outVec();
      compared++;
      if (got !== want) begin
        mismatched++;
        $display("FAIL %s tick %0d strobes got %b expected %b", curReq, tickN, got, want);
      end
      compared++;
      if (phaseFall !== tickN[0]) begin
        mismatched++;
        $display("FAIL R2 tick %0d phaseFall got %b expected %b", tickN, phaseFall, tickN[0]);
      end
      if (expTab.exists(tickN)) expTab.delete(tickN);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compared++;
      if (outVec() !== 8'h00 || phaseFall !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 reset outputs got %b/%b expected 00000000/0", outVec(), phaseFall);
      end
    end
    rst = 1'b0;
    monOn = 1'b1;

    // R4 R7 R8: slow-grade read on port A
    curReq = "R4 R7 R8";
    step(1, 0, 0, 0, 0);
    idle(14);

    // R6: slow-grade write on port A
    curReq = "R6";
    alignA();
    step(1, 1, 0, 0, 0);
    idle(12);

    // R11: interleaved traffic on both ports
    curReq = "R11";
    alignA();
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    idle(20);

    // R3: commands in the wrong half are ignored
    curReq = "R3";
    alignA();
    idle(1);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    idle(20);

    // R9: reads every cycle on both ports
    curReq = "R9";
    alignA();
    for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 0);
    idle(20);

    // R10: grade change with bursts in flight
    curReq = "R10";
    alignA();
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    idle(3);
    step(1, 0, 1, 0, 1);
    idle(25);

    // R5 R6: fast grade, reads and writes on both ports
    curReq = "R5 R6";
    alignA();
    step(1, 0, 0, 0, 1);
    step(0, 0, 1, 0, 1);
    step(1, 1, 0, 0, 1);
    step(0, 0, 1, 1, 1);
    step(1, 0, 0, 0, 1);
    idle(26);

    // R10: back to the slow grade with nothing in flight
    curReq = "R10 R4";
    idle(1);
    step(0, 0, 0, 0, 0);
    alignA();
    step(1, 0, 0, 0, 0);
    idle(16);

    monOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule